// File: doc/BRIEF.md
# Integer Status Flag Update Unit

This block keeps the integer status flags that follow an arithmetic or logical operation: a carry pair (full width and lower half), an overflow pair (full width and lower half), a sticky summary-overflow bit, and a 4-bit condition field for the result. The execution unit that produced the result hands over its operand list and result. The block returns the flag state as it stands after that operation. The operand list holds up to three register operands plus an optional immediate. When the immediate is present it is placed directly after the last register operand.

The carry is found by comparing each operand with the result, not from an adder carry-out. An operand that is unsigned-greater than the result implies a wrap. For add-type operations the lower-half carry instead uses a parity rule on bit W/2. The overflow pair is read from the sign bits of the first two operands and of the result. A divider can override both overflow bits directly. Flags that the operation writes by itself can be masked out of the carry update. All updates take effect on one clock edge when the strobe is high. Without the strobe, the flags hold their values.

Top module: `flag_update_unit`

## Requirements
- R1: When `invert_first` is high, operand 0 of the list is bitwise inverted before any carry or overflow evaluation.
- R2: With `carry_en` high, `ca` becomes 1 when any operand in the list is unsigned-greater than `result`, and 0 otherwise.
- R3: With `carry_en` and `is_add` high, `ca32` becomes `result[32]` XOR `op0[32]` XOR `op1[32]`, where op1 counts as 0 when the list holds fewer than two operands.
- R4: With `carry_en` high and `is_add` low, `ca32` becomes 1 when the low 32 bits of any operand are unsigned-greater than the low 32 bits of `result`.
- R5: `done_mask[0]` high leaves `ca` unchanged, and `done_mask[1]` high leaves `ca32` unchanged, even with `carry_en` high.
- R6: With `ov_en` high, no override and at least two operands, `ov` is 1 when op0 and op1 have equal bit 63 and `result[63]` differs from them. `ov32` applies the same rule to bit 31.
- R7: With `ov_en` high and `divov_valid` high, both `ov` and `ov32` take `divov_value`. With fewer than two operands and no override, `ov`, `ov32` and `so` are unchanged.
- R8: Whenever the overflow pair is written, `so` becomes its old value OR the new `ov`. `so` is never cleared except by reset.
- R9: With `rec_en` high, `cr0` becomes {negative, positive, zero, so}, from bit 3 down to bit 0. The first three bits come from `result` read as a signed 64-bit number, and bit 0 is the `so` value after this update.
- R10: Reset clears every flag to 0. When `valid` is low, every flag holds. When `carry_en`, `ov_en` or `rec_en` is low, the corresponding group of flags holds.
- R11: The operand list is the first `n_ops` register operands. When `imm_en` is high, `imm` follows them, and it then takes part in the carry compare and, as op1 when `n_ops` is 1, in the overflow rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Update strobe |
| reg_ops | input | NREG*W | Register operands, element 0 first |
| n_ops | input | NW | Number of register operands in use |
| imm_en | input | 1 | Immediate is an extra operand |
| imm | input | W | Immediate value |
| result | input | W | Operation result |
| is_add | input | 1 | Add-type operation (lower-half carry parity rule) |
| invert_first | input | 1 | Invert operand 0 before evaluation |
| carry_en | input | 1 | Update the carry pair |
| ov_en | input | 1 | Update the overflow pair and `so` |
| rec_en | input | 1 | Update `cr0` |
| divov_valid | input | 1 | Divide-overflow override present |
| divov_value | input | 1 | Override value for `ov` and `ov32` |
| done_mask | input | 2 | Bit 0 blocks `ca`, bit 1 blocks `ca32` |
| ca | output | 1 | Carry |
| ca32 | output | 1 | Lower-half carry |
| ov | output | 1 | Overflow |
| ov32 | output | 1 | Lower-half overflow |
| so | output | 1 | Sticky summary overflow |
| cr0 | output | 4 | {negative, positive, zero, so} |

## Verification
The first carry stimulus is an all-ones plus one that wraps to zero. It is then repeated with non-add operands whose upper half is larger than the result but whose lower half is not, which separates the parity rule for `ca32` from the compare rule. A subtract built with an inverted first operand shows that the inversion happens before the compare. A case where only the immediate exceeds the result shows that the immediate is really part of the operand list. For overflow, separate patterns wrap only the full width or only the lower half, so the two sign positions are checked apart. The override, the single-operand case and cleared enables show which writes are allowed, and `so` is watched across later writes where `ov` returns to 0. Negative, positive and zero results check the ordering of `cr0`.

// File: rtl/flagu_pkg.sv
package flagu_pkg;

    typedef struct packed {
        logic       ca;
        logic       ca32;
        logic       ov;
        logic       ov32;
        logic       so;
        logic [3:0] cr0;
    } flags_t;

endpackage

// File: rtl/flagu_operands.sv
module flagu_operands #(
    parameter  int W    = 64,
    parameter  int NREG = 3,
    localparam int NOPS = NREG + 1,
    localparam int NW   = $clog2(NREG + 1),
    localparam int CW   = $clog2(NOPS + 1)
) (
    input  logic [NREG-1:0][W-1:0] reg_ops,
    input  logic [NW-1:0]          n_ops,
    input  logic                   imm_en,
    input  logic [W-1:0]           imm,
    input  logic                   invert_first,
    output logic [NOPS-1:0][W-1:0] ops,
    output logic [NOPS-1:0]        used,
    output logic [CW-1:0]          count
);

    always_comb begin
        for (int i = 0; i < NOPS; i++) begin
            ops[i]  = '0;
            used[i] = 1'b0;
            if (i < NREG && NW'(i) < n_ops) begin
                ops[i]  = reg_ops[(i < NREG) ? i : 0];
                used[i] = 1'b1;
            end else if (imm_en && NW'(i) == n_ops) begin
                ops[i]  = imm;
                used[i] = 1'b1;
            end
        end
        if (invert_first) begin
            ops[0] = ~ops[0];
        end
        count = CW'(n_ops) + CW'(imm_en);
    end

endmodule

// File: rtl/flagu_carry.sv
module flagu_carry #(
    parameter  int W    = 64,
    parameter  int NOPS = 4,
    localparam int H    = W / 2
) (
    input  logic [NOPS-1:0][W-1:0] ops,
    input  logic [NOPS-1:0]        used,
    input  logic [W-1:0]           res,
    input  logic                   is_add,
    output logic                   ca,
    output logic                   ca32
);

    logic [NOPS-1:0] above_full;
    logic [NOPS-1:0] above_low;

    for (genvar g = 0; g < NOPS; g++) begin : g_cmp
        assign above_full[g] = used[g] && (ops[g] > res);
        assign above_low[g]  = used[g] && (ops[g][H-1:0] > res[H-1:0]);
    end

    logic parity_h;
    assign parity_h = res[H] ^ ops[0][H] ^ (used[1] & ops[1][H]);

    assign ca   = |above_full;
    assign ca32 = is_add ? parity_h : |above_low;

endmodule

// File: rtl/flagu_ovf.sv
module flagu_ovf #(
    parameter  int W = 64,
    localparam int H = W / 2
) (
    input  logic [W-1:0] op0,
    input  logic [W-1:0] op1,
    input  logic [W-1:0] res,
    input  logic         two_ops,
    input  logic         divov_valid,
    input  logic         divov_value,
    output logic         ov,
    output logic         ov32,
    output logic         wr
);

    logic sign_ov;
    logic sign_ov32;

    assign sign_ov   = (op0[W-1] == op1[W-1]) && (res[W-1] != op0[W-1]);
    assign sign_ov32 = (op0[H-1] == op1[H-1]) && (res[H-1] != op0[H-1]);

    assign wr   = divov_valid | two_ops;
    assign ov   = divov_valid ? divov_value : sign_ov;
    assign ov32 = divov_valid ? divov_value : sign_ov32;

endmodule

// File: rtl/flagu_sign.sv
module flagu_sign #(
    parameter int W = 64
) (
    input  logic [W-1:0] res,
    output logic         neg,
    output logic         pos,
    output logic         zero
);

    assign zero = (res == '0);
    assign neg  = res[W-1];
    assign pos  = !res[W-1] && !zero;

endmodule

// File: rtl/flag_update_unit.sv
module flag_update_unit
    import flagu_pkg::*;
#(
    parameter  int W    = 64,
    parameter  int NREG = 3,
    localparam int NW   = $clog2(NREG + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   valid,
    input  logic [NREG-1:0][W-1:0] reg_ops,
    input  logic [NW-1:0]          n_ops,
    input  logic                   imm_en,
    input  logic [W-1:0]           imm,
    input  logic [W-1:0]           result,
    input  logic                   is_add,
    input  logic                   invert_first,
    input  logic                   carry_en,
    input  logic                   ov_en,
    input  logic                   rec_en,
    input  logic                   divov_valid,
    input  logic                   divov_value,
    input  logic [1:0]             done_mask,
    output logic                   ca,
    output logic                   ca32,
    output logic                   ov,
    output logic                   ov32,
    output logic                   so,
    output logic [3:0]             cr0
);

    localparam int NOPS = NREG + 1;
    localparam int CW   = $clog2(NOPS + 1);

    logic [NOPS-1:0][W-1:0] ops;
    logic [NOPS-1:0]        used;
    logic [CW-1:0]          count;

    flagu_operands #(.W(W), .NREG(NREG)) u_ops (
        .reg_ops      (reg_ops),
        .n_ops        (n_ops),
        .imm_en       (imm_en),
        .imm          (imm),
        .invert_first (invert_first),
        .ops          (ops),
        .used         (used),
        .count        (count)
    );

    logic ca_c, ca32_c;

    flagu_carry #(.W(W), .NOPS(NOPS)) u_carry (
        .ops    (ops),
        .used   (used),
        .res    (result),
        .is_add (is_add),
        .ca     (ca_c),
        .ca32   (ca32_c)
    );

    logic ov_c, ov32_c, ov_wr;

    flagu_ovf #(.W(W)) u_ovf (
        .op0         (ops[0]),
        .op1         (ops[1]),
        .res         (result),
        .two_ops     (count >= CW'(2)),
        .divov_valid (divov_valid),
        .divov_value (divov_value),
        .ov          (ov_c),
        .ov32        (ov32_c),
        .wr          (ov_wr)
    );

    logic neg_c, pos_c, zero_c;

    flagu_sign #(.W(W)) u_sign (
        .res  (result),
        .neg  (neg_c),
        .pos  (pos_c),
        .zero (zero_c)
    );

    flags_t cur_q, nxt;

    always_comb begin
        nxt = cur_q;
        if (carry_en) begin
            if (!done_mask[0]) nxt.ca   = ca_c;
            if (!done_mask[1]) nxt.ca32 = ca32_c;
        end
        if (ov_en && ov_wr) begin
            nxt.ov   = ov_c;
            nxt.ov32 = ov32_c;
            nxt.so   = cur_q.so | ov_c;
        end
        if (rec_en) begin
            nxt.cr0 = {neg_c, pos_c, zero_c, nxt.so};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (valid) begin
            cur_q <= nxt;
        end
    end

    assign ca   = cur_q.ca;
    assign ca32 = cur_q.ca32;
    assign ov   = cur_q.ov;
    assign ov32 = cur_q.ov32;
    assign so   = cur_q.so;
    assign cr0  = cur_q.cr0;

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable({ca, ca32, ov, ov32, so, cr0}));

    p_mask_ca_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && done_mask[0]) |=> $stable(ca));

    p_mask_ca32_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && done_mask[1]) |=> $stable(ca32));

    p_so_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        so |=> so);

    p_cr0_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && rec_en) |=> ($countones(cr0[3:1]) == 1 && cr0[0] == so));

    p_ov_untouched_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !divov_valid && (CW'(n_ops) + CW'(imm_en)) < CW'(2))
            |=> $stable({ov, ov32, so}));

endmodule

// File: tb/flag_update_unit_test.sv
module flag_update_unit_test;

    localparam int W = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            valid = 1'b0;
    logic [2:0][W-1:0] reg_ops = '0;
    logic [1:0]      n_ops = '0;
    logic            imm_en = 1'b0;
    logic [W-1:0]    imm = '0;
    logic [W-1:0]    result = '0;
    logic            is_add = 1'b0;
    logic            invert_first = 1'b0;
    logic            carry_en = 1'b0;
    logic            ov_en = 1'b0;
    logic            rec_en = 1'b0;
    logic            divov_valid = 1'b0;
    logic            divov_value = 1'b0;
    logic [1:0]      done_mask = '0;
    logic            ca, ca32, ov, ov32, so;
    logic [3:0]      cr0;

    always #10 clk = ~clk;

    flag_update_unit uut (
        .clk(clk), .rst_n(rst_n), .valid(valid), .reg_ops(reg_ops),
        .n_ops(n_ops), .imm_en(imm_en), .imm(imm), .result(result),
        .is_add(is_add), .invert_first(invert_first), .carry_en(carry_en),
        .ov_en(ov_en), .rec_en(rec_en), .divov_valid(divov_valid),
        .divov_value(divov_value), .done_mask(done_mask),
        .ca(ca), .ca32(ca32), .ov(ov), .ov32(ov32), .so(so), .cr0(cr0)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];

    // model state
    logic m_ca = 0, m_ca32 = 0, m_ov = 0, m_ov32 = 0, m_so = 0;
    logic [3:0] m_cr0 = '0;

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [W-1:0] c, input logic [1:0] n,
                         input logic ie, input logic [W-1:0] iv,
                         input logic [W-1:0] res, input logic add,
                         input logic inv, input logic cen, input logic oen,
                         input logic ren, input logic dv, input logic dvv,
                         input logic [1:0] mask, input logic strobe,
                         input string tag);
        logic [W-1:0] lst[4];
        int cnt;
        logic any_full, any_low, op1_32, sa, sb, sr, ta, tb, tr;
        logic n_ca, n_ca32, n_ov, n_ov32, n_so;
        logic [3:0] n_cr0;
        @(negedge clk);
        reg_ops[0] = a; reg_ops[1] = b; reg_ops[2] = c; n_ops = n;
        imm_en = ie; imm = iv; result = res; is_add = add;
        invert_first = inv; carry_en = cen; ov_en = oen; rec_en = ren;
        divov_valid = dv; divov_value = dvv; done_mask = mask; valid = strobe;
        // build operand list per R11, then R1 inversion
        cnt = 0;
        if (n > 0) begin lst[cnt] = a; cnt++; end
        if (n > 1) begin lst[cnt] = b; cnt++; end
        if (n > 2) begin lst[cnt] = c; cnt++; end
        if (ie) begin lst[cnt] = iv; cnt++; end
        for (int k = cnt; k < 4; k++) lst[k] = '0;
        if (inv) lst[0] = ~lst[0];
        any_full = 0; any_low = 0;
        for (int k = 0; k < cnt; k++) begin
            if (lst[k] > res) any_full = 1;
            if (lst[k][31:0] > res[31:0]) any_low = 1;
        end
        op1_32 = (cnt >= 2) ? lst[1][32] : 1'b0;
        n_ca = m_ca; n_ca32 = m_ca32; n_ov = m_ov; n_ov32 = m_ov32;
        n_so = m_so; n_cr0 = m_cr0;
        if (cen) begin
            if (!mask[0]) n_ca = any_full;
            if (!mask[1]) n_ca32 = add ? (res[32] ^ lst[0][32] ^ op1_32) : any_low;
        end
        if (oen && (dv || cnt >= 2)) begin
            if (dv) begin
                n_ov = dvv; n_ov32 = dvv;
            end else begin
                sa = lst[0][63]; sb = lst[1][63]; sr = res[63];
                ta = lst[0][31]; tb = lst[1][31]; tr = res[31];
                n_ov   = (sa == sb) && (sr != sa);
                n_ov32 = (ta == tb) && (tr != ta);
            end
            n_so = m_so | n_ov;
        end
        if (ren) begin
            n_cr0 = {$signed(res) < 0, $signed(res) > 0, res == '0, n_so};
        end
        if (strobe) begin
            m_ca = n_ca; m_ca32 = n_ca32; m_ov = n_ov; m_ov32 = n_ov32;
            m_so = n_so; m_cr0 = n_cr0;
        end
        exp_q.push_back({m_ca, m_ca32, m_ov, m_ov32, m_so, m_cr0});
        tag_q.push_back(tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            if (exp_q.size() != 0) begin
                logic [8:0] e;
                string t;
                #5;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if ({ca, ca32, ov, ov32, so, cr0} !== e) begin
                    n_bad++;
                    $display("FAIL %s: got %b expected %b", t,
                             {ca, ca32, ov, ov32, so, cr0}, e);
                end
            end
        end
    end

    localparam logic [W-1:0] ONES = '1;
    localparam logic [W-1:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [W-1:0] MINN = 64'h8000_0000_0000_0000;

    initial begin
        repeat (3) @(negedge clk);
        // reset state (R10)
        n_cmp++;
        if ({ca, ca32, ov, ov32, so, cr0} !== 9'b0) begin
            n_bad++;
            $display("FAIL R10 reset: got %b expected %b",
                     {ca, ca32, ov, ov32, so, cr0}, 9'b0);
        end
        rst_n = 1'b1;
        //     a      b     c  n  ie imm res   add inv cen oen ren dv dvv mask stb
        apply(ONES, 64'd1, 0, 2, 0, 0, 64'd0, 1, 0, 1, 0, 1, 0, 0, 2'b00, 1, "R2 R3 R9 add wrap to zero");
        apply(64'h1_0000_0000, 64'd0, 0, 2, 0, 0, 64'h8000_0000, 0, 0, 1, 0, 0, 0, 0, 2'b00, 1, "R4 non-add low-half compare");
        apply(64'd5, 64'd7, 0, 2, 0, 0, 64'd2, 1, 1, 1, 0, 0, 0, 0, 2'b00, 1, "R1 inverted first operand");
        apply(64'd1, 64'd1, 0, 2, 0, 0, 64'd2, 1, 0, 1, 0, 0, 0, 0, 2'b01, 1, "R5 ca masked");
        apply(ONES, 64'd1, 0, 2, 0, 0, 64'd0, 0, 0, 1, 0, 0, 0, 0, 2'b10, 1, "R5 ca32 masked");
        apply(MAXP, 64'd1, 0, 2, 0, 0, MINN, 1, 0, 0, 1, 1, 0, 0, 2'b00, 1, "R6 R9 full overflow negative");
        apply(64'h7FFF_FFFF, 64'd1, 0, 2, 0, 0, 64'h8000_0000, 1, 0, 0, 1, 1, 0, 0, 2'b00, 1, "R6 R8 half overflow, so sticky");
        apply(64'd9, 64'd3, 0, 2, 0, 0, 64'd5, 0, 0, 0, 1, 1, 1, 0, 2'b00, 1, "R7 R8 override clears ov, so held");
        apply(64'd9, 64'd3, 0, 2, 0, 0, 64'd5, 0, 0, 0, 1, 0, 1, 1, 2'b00, 1, "R7 override sets ov");
        apply(MAXP, 0, 0, 1, 0, 0, 64'd0, 0, 0, 0, 1, 0, 0, 0, 2'b00, 1, "R7 single operand leaves ov");
        apply(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 2'b00, 1, "R7 override clears again");
        apply(MAXP, 0, 0, 1, 1, 64'd1, MINN, 1, 0, 0, 1, 0, 0, 0, 2'b00, 1, "R11 immediate as op1 for overflow");
        apply(64'd0, 0, 0, 1, 1, 64'd5, 64'd3, 0, 0, 1, 0, 0, 0, 0, 2'b00, 1, "R11 immediate in carry compare");
        apply(64'd1, 64'd2, 64'd9, 3, 0, 0, 64'd4, 0, 0, 1, 0, 1, 0, 0, 2'b00, 1, "R2 R9 third operand, positive");
        apply(ONES, 64'd1, 0, 2, 0, 0, 64'd0, 1, 0, 1, 1, 1, 0, 0, 2'b00, 0, "R10 no strobe holds");
        apply(ONES, 64'd1, 0, 2, 0, 0, MINN, 1, 0, 0, 0, 0, 0, 0, 2'b00, 1, "R10 enables low hold");
        apply(64'd3, 64'd4, 0, 2, 0, 0, 64'd7, 1, 0, 1, 1, 1, 0, 0, 2'b00, 1, "R3 R6 R9 plain add");
        @(negedge clk);
        valid = 1'b0;
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule